// File: doc/BRIEF.md
# JTAG Debug Command Dispatcher

This block sits behind a JTAG TAP state machine and holds the 10-bit debug command word that steers every later data scan. The command is loaded at the end of an instruction scan and decoded into four fields: a transfer direction, a go request, an exit request and a 7-bit register-select code. The select code is driven out to the debug register file so that the right register answers the next data scan.

During the following data scan the block moves a 32-bit word between TDI/TDO and the selected register. It samples read data at Capture-DR and shifts it out LSB-first. For a write, it presents the shifted-in word with a write strobe at Update-DR. The same Update-DR also releases any pending go or exit request to the core, as single-cycle pulses. The no-register selection is handled as a one-bit bypass path. Two select codes behave as a read-only and a write-only register; for these the direction bit has no effect.

The TAP state decoding and the core's own step/resume logic are outside the block. The TAP delivers state strobes sampled on TCK, and the core reports whether it is halted in debug mode.

Top module: `dbg_cmd_dispatch`

## Requirements
- R1: While `trst_n` or `por_n` is low, the command word holds 10'b10_0000_0010. Written as {rw, go, ex, sel[6:0]}, this is read direction, go and exit clear, and `reg_sel` = 2. The reset is asynchronous.
- R2: A TCK edge with `tlr` high returns the command word to the value of R1, whatever else is strobed.
- R3: At Capture-IR the 10-bit instruction path loads the status pattern 10'b00_0000_0001 and shifts it out LSB-first on `tdo` during Shift-IR. The shift path shifts in from TDI, and at Update-IR the command word takes the 10 bits shifted in. The first bit shifted in lands in bit 0, so bit 9 is rw (1 = read), bit 8 is go, bit 7 is ex and bits 6:0 are the select code.
- R4: For a read of an ordinary select code, `rd_stb` is high for exactly the Capture-DR cycle and `rd_data` is loaded into the 32-bit shift path. The loaded value appears on `tdo` LSB-first during the first 32 Shift-DR cycles.
- R5: For a write of an ordinary select code, `wr_stb` is high for exactly the Update-DR cycle, and `wr_data` then equals the last 32 bits shifted in, with the first bit shifted in as bit 0.
- R6: Select code 7'h7F (no register) is a one-bit bypass. Capture loads 0, `tdo` shows TDI delayed by one shift, and neither `rd_stb` nor `wr_stb` fires for either direction.
- R7: Select code 7'h02 is read-only: it is always read at Capture-DR and never written. Select code 7'h03 is write-only: it is always written at Update-DR and never read.
- R8: `go_pulse` is a one-cycle pulse in the cycle after an Update-DR whose command has go set and whose select code is 7'h10 (CPU scan chain) or 7'h7F. For any other select code the go bit has no effect.
- R9: `exit_pulse` accompanies `go_pulse` exactly when the ex bit is also set. With ex clear, only `go_pulse` fires (step and return to debug).
- R10: No go or exit pulse is produced unless `in_debug` is high in the Update-DR cycle.
- R11: Go and exit pulses come only from Update-DR. Loading a go command through Update-IR alone produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tlr | input | 1 | TAP in Test-Logic-Reset |
| cap_ir | input | 1 | TAP in Capture-IR |
| shf_ir | input | 1 | TAP in Shift-IR |
| upd_ir | input | 1 | TAP in Update-IR |
| cap_dr | input | 1 | TAP in Capture-DR |
| shf_dr | input | 1 | TAP in Shift-DR |
| upd_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| rd_data | input | 32 | Read data of the selected debug register |
| in_debug | input | 1 | Core is halted in debug mode |
| reg_sel | output | 7 | Register-select code of the current command |
| rd_stb | output | 1 | Read strobe, Capture-DR cycle |
| wr_stb | output | 1 | Write strobe, Update-DR cycle |
| wr_data | output | 32 | Write data |
| go_pulse | output | 1 | Execute the instruction held in the CPU scan chain |
| exit_pulse | output | 1 | Leave debug mode after the go |

## Verification
The assertions assume that the TAP state strobes are mutually exclusive and that each Update-DR strobe lasts one TCK cycle, as a real TAP guarantees. They also assume that `in_debug` and `rd_data` are stable around the edge that samples them. The bench keeps to this by driving every strobe through one step task that raises at most one state strobe per cycle, on the falling edge. It walks capture, shift and update in TAP order and changes `in_debug` only between scans.

// File: rtl/dbg_cmd_dispatch.sv
module dbg_cmd_dispatch #(
  parameter int          DW         = 32,
  parameter logic [6:0]  SEL_CPU    = 7'h10,
  parameter logic [6:0]  SEL_NONE   = 7'h7F,
  parameter logic [6:0]  SEL_RDONLY = 7'h02,
  parameter logic [6:0]  SEL_WRONLY = 7'h03,
  parameter logic [9:0]  CMD_RST    = 10'b10_0000_0010,
  parameter logic [9:0]  IR_STATUS  = 10'b00_0000_0001
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          por_n,
  input  logic          tlr,
  input  logic          cap_ir,
  input  logic          shf_ir,
  input  logic          upd_ir,
  input  logic          cap_dr,
  input  logic          shf_dr,
  input  logic          upd_dr,
  input  logic          tdi,
  output logic          tdo,
  input  logic [DW-1:0] rd_data,
  input  logic          in_debug,
  output logic [6:0]    reg_sel,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          go_pulse,
  output logic          exit_pulse
);
  localparam int CW = 10;

  logic [CW-1:0] cmd, ir_sr;
  logic [DW-1:0] dr_sr;
  logic          byp, go_q, exit_q;

  wire rst_n   = trst_n & por_n;
  wire cmd_rd  = cmd[9];
  wire cmd_go  = cmd[8];
  wire cmd_ex  = cmd[7];
  wire bypass  = cmd[6:0] == SEL_NONE;
  wire is_ro   = cmd[6:0] == SEL_RDONLY;
  wire is_wo   = cmd[6:0] == SEL_WRONLY;
  wire rd_ok   = !bypass && !is_wo && (cmd_rd || is_ro);
  wire wr_ok   = !bypass && !is_ro && (!cmd_rd || is_wo);
  wire go_ok   = cmd_go && in_debug && (cmd[6:0] == SEL_CPU || bypass);

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)      cmd <= CMD_RST;
    else if (tlr)    cmd <= CMD_RST;
    else if (upd_ir) cmd <= ir_sr;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)      ir_sr <= '0;
    else if (cap_ir) ir_sr <= IR_STATUS;
    else if (shf_ir) ir_sr <= {tdi, ir_sr[CW-1:1]};

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                    dr_sr <= '0;
    else if (cap_dr && rd_ok)      dr_sr <= rd_data;
    else if (shf_dr && !bypass)    dr_sr <= {tdi, dr_sr[DW-1:1]};

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)                  byp <= 1'b0;
    else if (cap_dr)             byp <= 1'b0;
    else if (shf_dr && bypass)   byp <= tdi;

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) begin
      go_q   <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      go_q   <= !tlr && upd_dr && go_ok;
      exit_q <= !tlr && upd_dr && go_ok && cmd_ex;
    end

  assign reg_sel    = cmd[6:0];
  assign rd_stb     = cap_dr && rd_ok;
  assign wr_stb     = upd_dr && wr_ok;
  assign wr_data    = dr_sr;
  assign go_pulse   = go_q;
  assign exit_pulse = exit_q;
  assign tdo        = shf_ir ? ir_sr[0] : (bypass ? byp : dr_sr[0]);
endmodule

// File: rtl/dbg_cmd_dispatch_chk.sv
module dbg_cmd_dispatch_chk #(
  parameter logic [6:0] SEL_CPU    = 7'h10,
  parameter logic [6:0] SEL_NONE   = 7'h7F,
  parameter logic [6:0] SEL_RDONLY = 7'h02,
  parameter logic [6:0] SEL_WRONLY = 7'h03,
  parameter logic [6:0] SEL_RST    = 7'h02
) (
  input logic       tck,
  input logic       trst_n,
  input logic       por_n,
  input logic       tlr,
  input logic       upd_dr,
  input logic       in_debug,
  input logic [6:0] reg_sel,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       go_pulse,
  input logic       exit_pulse
);
  wire rst_n = trst_n & por_n;

  AST_RESET_SEL: assert property (@(posedge tck) disable iff (!rst_n)
    !$past(rst_n) |-> reg_sel == SEL_RST); // R1
  AST_TLR_SEL: assert property (@(posedge tck) disable iff (!rst_n)
    $past(tlr) |-> reg_sel == SEL_RST); // R2
  AST_STB_EXCL: assert property (@(posedge tck) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R7
  AST_NO_WR_BYPASS: assert property (@(posedge tck) disable iff (!rst_n)
    wr_stb |-> reg_sel != SEL_NONE && reg_sel != SEL_RDONLY); // R6
  AST_NO_RD_WRONLY: assert property (@(posedge tck) disable iff (!rst_n)
    rd_stb |-> reg_sel != SEL_NONE && reg_sel != SEL_WRONLY); // R7
  AST_GO_SEL: assert property (@(posedge tck) disable iff (!rst_n)
    go_pulse |-> $past(reg_sel) == SEL_CPU || $past(reg_sel) == SEL_NONE); // R8
  AST_GO_SINGLE: assert property (@(posedge tck) disable iff (!rst_n)
    go_pulse |=> !go_pulse); // R8
  AST_EXIT_WITH_GO: assert property (@(posedge tck) disable iff (!rst_n)
    exit_pulse |-> go_pulse); // R9
  AST_GO_IN_DEBUG: assert property (@(posedge tck) disable iff (!rst_n)
    go_pulse |-> $past(in_debug)); // R10
  AST_GO_AFTER_UPD: assert property (@(posedge tck) disable iff (!rst_n)
    go_pulse |-> $past(upd_dr)); // R11
endmodule

bind dbg_cmd_dispatch dbg_cmd_dispatch_chk #(
  .SEL_CPU(SEL_CPU), .SEL_NONE(SEL_NONE), .SEL_RDONLY(SEL_RDONLY),
  .SEL_WRONLY(SEL_WRONLY), .SEL_RST(CMD_RST[6:0])
) chk_i (
  .tck(tck), .trst_n(trst_n), .por_n(por_n), .tlr(tlr), .upd_dr(upd_dr),
  .in_debug(in_debug), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .go_pulse(go_pulse), .exit_pulse(exit_pulse)
);

// File: tb/dbg_cmd_dispatch_tb_top.sv
`timescale 1ns/1ps
module dbg_cmd_dispatch_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic trst_n = 0, por_n = 0, tlr = 0, cap_ir = 0, shf_ir = 0, upd_ir = 0;
  logic cap_dr = 0, shf_dr = 0, upd_dr = 0, tdi = 0, in_debug = 0;
  logic [31:0] rd_data = '0;
  logic        tdo, rd_stb, wr_stb, go_pulse, exit_pulse;
  logic [6:0]  reg_sel;
  logic [31:0] wr_data;

  dbg_cmd_dispatch dut_i (
    .tck(clk), .trst_n(trst_n), .por_n(por_n), .tlr(tlr), .cap_ir(cap_ir),
    .shf_ir(shf_ir), .upd_ir(upd_ir), .cap_dr(cap_dr), .shf_dr(shf_dr),
    .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo), .rd_data(rd_data),
    .in_debug(in_debug), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .go_pulse(go_pulse), .exit_pulse(exit_pulse));

  int n_chk = 0, n_bad = 0;
  int c_rd, c_wr, c_go, c_ex;
  logic [31:0] wd;
  logic tdo_s;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    c_rd = 0; c_wr = 0; c_go = 0; c_ex = 0; wd = 'x;
  endtask

  task automatic step(input logic ci, input logic si, input logic ui, input logic cd,
                      input logic sd, input logic ud, input logic t);
    @(negedge clk);
    cap_ir = ci; shf_ir = si; upd_ir = ui; cap_dr = cd; shf_dr = sd; upd_dr = ud; tdi = t;
    #1;
    tdo_s = tdo;
    if (rd_stb) c_rd++;
    if (wr_stb) begin c_wr++; wd = wr_data; end
    if (go_pulse) c_go++;
    if (exit_pulse) c_ex++;
  endtask

  task automatic ir_scan(input logic [9:0] cmd, output logic [9:0] st);
    clr();
    step(1,0,0,0,0,0,0);
    for (int i = 0; i < 10; i++) begin
      step(0,1,0,0,0,0,cmd[i]);
      st[i] = tdo_s;
    end
    step(0,0,1,0,0,0,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
  endtask

  task automatic dr_scan(input logic [31:0] din, output logic [31:0] dout);
    clr();
    step(0,0,0,1,0,0,0);
    for (int i = 0; i < 32; i++) begin
      step(0,0,0,0,1,0,din[i]);
      dout[i] = tdo_s;
    end
    step(0,0,0,0,0,1,0);
    step(0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
  endtask

  function automatic logic [9:0] mk(input logic rw, input logic g, input logic x, input logic [6:0] s);
    return {rw, g, x, s};
  endfunction

  logic [9:0]  st;
  logic [31:0] dout;

  task automatic t_reset();
    #1;
    chk("R1 sel in reset", {25'd0, reg_sel}, 32'd2);
    chk("R1 go in reset", {31'd0, go_pulse}, 0);
    @(negedge clk); trst_n = 1; por_n = 1;
    rd_data = 32'hCAFE_0001;
    dr_scan(32'h0, dout);
    chk("R1 reset cmd reads sel 2", dout, 32'hCAFE_0001);
    chk("R1 reset cmd rd_stb", c_rd, 1);
  endtask

  task automatic t_ir_path();
    ir_scan(mk(1,0,0,7'h05), st);
    chk("R3 capture-IR status", {22'd0, st}, 32'h001);
    chk("R3 sel field", {25'd0, reg_sel}, 32'h05);
    chk("R11 no go from update-IR", c_go, 0);
  endtask

  task automatic t_read();
    rd_data = 32'hA5C3_1E77;
    dr_scan(32'hFFFF_0000, dout);
    chk("R4 read shift-out", dout, 32'hA5C3_1E77);
    chk("R4 rd_stb count", c_rd, 1);
    chk("R4 no wr_stb", c_wr, 0);
  endtask

  task automatic t_write();
    ir_scan(mk(0,0,0,7'h05), st);
    dr_scan(32'h1234_5678, dout);
    chk("R5 wr_stb count", c_wr, 1);
    chk("R5 wr_data", wd, 32'h1234_5678);
    chk("R5 no rd_stb", c_rd, 0);
  endtask

  task automatic t_bypass();
    for (int rw = 0; rw < 2; rw++) begin
      ir_scan(mk(rw[0],0,0,7'h7F), st);
      dr_scan(32'h8000_0003, dout);
      chk("R6 bypass delay", dout, 32'h0000_0006);
      chk("R6 bypass no strobes", c_rd + c_wr, 0);
    end
  endtask

  task automatic t_ro_wo();
    rd_data = 32'h0BAD_F00D;
    ir_scan(mk(0,0,0,7'h02), st);
    dr_scan(32'h5555_AAAA, dout);
    chk("R7 read-only reads on write", dout, 32'h0BAD_F00D);
    chk("R7 read-only no write", c_wr, 0);
    ir_scan(mk(1,0,0,7'h03), st);
    dr_scan(32'h3C3C_C3C3, dout);
    chk("R7 write-only writes on read", c_wr, 1);
    chk("R7 write-only data", wd, 32'h3C3C_C3C3);
    chk("R7 write-only no read", c_rd, 0);
  endtask

  task automatic t_go();
    in_debug = 1;
    ir_scan(mk(0,1,0,7'h10), st);
    dr_scan(32'h0, dout);
    chk("R8 go on cpu select", c_go, 1);
    chk("R9 no exit without ex", c_ex, 0);
    ir_scan(mk(1,1,1,7'h10), st);
    dr_scan(32'h0, dout);
    chk("R9 go with ex", c_go, 1);
    chk("R9 exit with ex", c_ex, 1);
    ir_scan(mk(0,1,1,7'h05), st);
    dr_scan(32'h0, dout);
    chk("R8 go ignored other sel", c_go + c_ex, 0);
    ir_scan(mk(0,1,0,7'h7F), st);
    chk("R11 no go before update-DR", c_go, 0);
    dr_scan(32'h0, dout);
    chk("R8 go on no-register", c_go, 1);
  endtask

  task automatic t_nodebug();
    in_debug = 0;
    ir_scan(mk(0,1,1,7'h10), st);
    dr_scan(32'h0, dout);
    chk("R10 no go outside debug", c_go + c_ex, 0);
  endtask

  task automatic t_tlr();
    ir_scan(mk(0,0,0,7'h05), st);
    chk("R2 sel before tlr", {25'd0, reg_sel}, 32'h05);
    @(negedge clk); tlr = 1;
    @(negedge clk); tlr = 0; #1;
    chk("R2 sel after tlr", {25'd0, reg_sel}, 32'h02);
    rd_data = 32'h7777_1111;
    dr_scan(32'h0, dout);
    chk("R2 read direction after tlr", c_rd, 1);
  endtask

  task automatic t_trst();
    ir_scan(mk(0,0,0,7'h05), st);
    @(negedge clk); #1 trst_n = 0; #1;
    chk("R1 async trst", {25'd0, reg_sel}, 32'h02);
    @(negedge clk); trst_n = 1;
    ir_scan(mk(0,0,0,7'h06), st);
    @(negedge clk); #1 por_n = 0; #1;
    chk("R1 async por", {25'd0, reg_sel}, 32'h02);
    @(negedge clk); por_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ir_path();
    t_read();
    t_write();
    t_bypass();
    t_ro_wo();
    t_go();
    t_nodebug();
    t_tlr();
    t_trst();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end
endmodule